// File: doc/BRIEF.md
# Ping-Pong Power-Mode Gate Controller

This block owns the clock-gate enables of up to `NUM_UNITS` functional units. Each unit carries a use counter: an "on" request raises it and an "off" request lowers it. A unit's gate bit is set for as long as its counter is above zero, so several clients can share one unit without turning it off under each other.

The gate and clock words are never edited in place. The controller holds two shadow register sets and a 2-bit active-mode value. The mode value selects which set drives the outputs. When a gate bit has to change, the new gate word and the clock word from the request go into the set that is not in use. The active mode then moves to that set. After every switch a settle timer holds the controller busy for `SETTLE_CYCLES` cycles. Requests wait on a valid/ready handshake until the timer runs out, and none are lost.

Top module: `pg_gate_ctrl`

## Requirements
- R1: After reset every gate bit is 0, the clock word is 0, `busy` and `err` are low, `req_ready` is high, and `mode` equals the `INIT_MODE` parameter.
- R2: An accepted "on" request raises the addressed unit's counter by one and an "off" request lowers it by one. The unit's gate bit (bit position = unit index) is 1 exactly when its counter is nonzero.
- R3: An "off" request to a unit whose counter is zero is rejected. No counter, gate bit, clock word or mode changes.
- R4: A request whose unit index is `NUM_UNITS` or greater is rejected and changes no state.
- R5: An "on" request to a unit whose counter is at its maximum (2^CNT_W - 1) is rejected and changes no state.
- R6: If an accepted request leaves the unit's gate bit at its current value, only the counter changes. Gate, clock word and mode stay unchanged, and `busy` does not rise.
- R7: When a gate bit must change and `mode` is 1, set 0 is written and `mode` becomes 0. When `mode` is 0 or 2, set 1 is written and `mode` becomes 1. The outputs show set 1 when `mode` is 1 and set 0 otherwise. The new gate word is the old one with the single bit flipped.
- R8: When a gate bit must change and `mode` is 3, the request is rejected. No state changes and no settle period starts.
- R9: After every mode switch, `busy` is high for exactly `SETTLE_CYCLES` cycles, starting in the cycle that follows the accepting edge.
- R10: `req_ready` is low while `busy` is high. A request held valid during that time is accepted once `req_ready` returns, and it is not dropped.
- R11: `err` is a one-cycle pulse in the cycle after each rejected request is accepted, and it is low otherwise.
- R12: A mode switch loads the request's `req_clock` value into the written set, so it becomes the visible clock word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_unit | input | IDX_W | Unit index |
| req_on | input | 1 | 1 = use the unit, 0 = release it |
| req_clock | input | CLK_W | Clock word stored on a switch |
| gate_vec | output | NUM_UNITS | Gate word of the active set |
| clock_word | output | CLK_W | Clock word of the active set |
| mode | output | 2 | Active power mode |
| busy | output | 1 | Settle period running |
| err | output | 1 | Previous accepted request was rejected |

## Verification
The main instance is built with `CNT_W=2`, which makes counter saturation reachable after three "on" requests. It uses `SETTLE_CYCLES=5`, so queued requests are released after short waits, and many set switches fit into one run. Two further instances start with `INIT_MODE` 2 and 3. They reach the less common mode value that still switches normally and the illegal value that blocks switching; neither can be reached from reset with the default mode. Unit indices up to 31 cover the out-of-range rejection.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
    typedef logic [1:0] pmode_t;

    localparam pmode_t MODE_SET0 = 2'd0;
    localparam pmode_t MODE_SET1 = 2'd1;
    localparam pmode_t MODE_ALT  = 2'd2;
    localparam pmode_t MODE_BAD  = 2'd3;

    typedef struct packed {
        logic reject;
        logic commit;
        logic do_switch;
    } pg_decision_t;

    // target of the next switch: leave set 1 for set 0, anything else goes to set 1
    function automatic pmode_t next_mode(pmode_t m);
        return (m == MODE_SET1) ? MODE_SET0 : MODE_SET1;
    endfunction

    function automatic logic shows_set1(pmode_t m);
        return m == MODE_SET1;
    endfunction
endpackage

// File: rtl/pg_unit_count.sv
`timescale 1ns/1ps
module pg_unit_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
    end
endmodule

// File: rtl/pg_settle_timer.sv
`timescale 1ns/1ps
module pg_settle_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(SETTLE_CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= TW'(SETTLE_CYCLES);
        else if (remain != '0)
            remain <= remain - TW'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/pg_gate_ctrl.sv
`timescale 1ns/1ps
module pg_gate_ctrl
    import pg_pkg::*;
#(
    parameter int     NUM_UNITS     = 20,
    parameter int     IDX_W         = 5,
    parameter int     CNT_W         = 4,
    parameter int     CLK_W         = 32,
    parameter int     SETTLE_CYCLES = 3200000,
    parameter pmode_t INIT_MODE     = MODE_SET0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [IDX_W-1:0]     req_unit,
    input  logic                 req_on,
    input  logic [CLK_W-1:0]     req_clock,
    output logic [NUM_UNITS-1:0] gate_vec,
    output logic [CLK_W-1:0]     clock_word,
    output logic [1:0]           mode,
    output logic                 busy,
    output logic                 err
);
    logic [CNT_W-1:0]     cnt_arr [NUM_UNITS];
    logic [NUM_UNITS-1:0] set0_gate, set1_gate;
    logic [CLK_W-1:0]     set0_clk, set1_clk;
    pmode_t               mode_q;
    logic                 err_q;

    logic [NUM_UNITS-1:0] cur_gate, sel_vec;
    logic [CLK_W-1:0]     cur_clk;
    logic [CNT_W-1:0]     cur_cnt, nxt_cnt;
    logic                 cur_bit, idx_ok, flip, take;
    pg_decision_t         dec;

    // per-unit use counters
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_cnt
        pg_unit_count #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .ld     (dec.commit && sel_vec[g]),
            .ld_val (nxt_cnt),
            .cnt    (cnt_arr[g])
        );
    end

    pg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (dec.do_switch),
        .busy  (busy)
    );

    assign cur_gate = shows_set1(mode_q) ? set1_gate : set0_gate;
    assign cur_clk  = shows_set1(mode_q) ? set1_clk  : set0_clk;

    // unit select and lookup
    always_comb begin
        cur_cnt = '0;
        cur_bit = 1'b0;
        idx_ok  = 1'b0;
        sel_vec = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (req_unit == IDX_W'(i)) begin
                cur_cnt    = cnt_arr[i];
                cur_bit    = cur_gate[i];
                idx_ok     = 1'b1;
                sel_vec[i] = 1'b1;
            end
        end
    end

    // request decision
    always_comb begin
        take    = req_valid && req_ready;
        nxt_cnt = req_on ? cur_cnt + CNT_W'(1) : cur_cnt - CNT_W'(1);
        flip    = ((nxt_cnt != '0) != cur_bit);
        dec.reject    = !idx_ok
                     || (req_on  && (cur_cnt == '1))
                     || (!req_on && (cur_cnt == '0))
                     || (flip && (mode_q == MODE_BAD));
        dec.commit    = take && !dec.reject;
        dec.do_switch = dec.commit && flip;
    end

    // shadow sets and mode
    always_ff @(posedge clk) begin
        if (rst) begin
            set0_gate <= '0;
            set1_gate <= '0;
            set0_clk  <= '0;
            set1_clk  <= '0;
            mode_q    <= INIT_MODE;
            err_q     <= 1'b0;
        end else begin
            err_q <= take && dec.reject;
            if (dec.do_switch) begin
                if (mode_q == MODE_SET1) begin
                    set0_gate <= cur_gate ^ sel_vec;
                    set0_clk  <= req_clock;
                end else begin
                    set1_gate <= cur_gate ^ sel_vec;
                    set1_clk  <= req_clock;
                end
                mode_q <= next_mode(mode_q);
            end
        end
    end

    assign req_ready  = !busy;
    assign gate_vec   = cur_gate;
    assign clock_word = cur_clk;
    assign mode       = mode_q;
    assign err        = err_q;
endmodule

// File: rtl/pg_gate_ctrl_chk.sv
`timescale 1ns/1ps
module pg_gate_ctrl_chk #(
    parameter int NUM_UNITS = 20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_ready,
    input logic                 busy,
    input logic                 err,
    input logic [1:0]           mode,
    input logic [NUM_UNITS-1:0] gate_vec
);
    AST_SWITCH_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> ($countones(gate_vec ^ $past(gate_vec)) == 1)); // R2

    AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (rst)
        err |-> ($stable(gate_vec) && $stable(mode))); // R3

    AST_MODE_NEVER_BAD: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd3) |=> (mode != 2'd3)); // R7

    AST_SWITCH_SETTLES: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> busy); // R9

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready); // R10

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> ($stable(gate_vec) && $stable(mode))); // R10
endmodule

bind pg_gate_ctrl pg_gate_ctrl_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .busy      (busy),
    .err       (err),
    .mode      (mode),
    .gate_vec  (gate_vec)
);

// File: tb/test_pg_gate_ctrl.sv
`timescale 1ns/1ps
module test_pg_gate_ctrl;
    localparam int NU     = 20;
    localparam int SETTLE = 5;
    localparam int MAXC   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        r_valid = 1'b0, r_on = 1'b0;
    logic [4:0]  r_unit  = '0;
    logic [7:0]  r_clk   = '0;
    logic        d_ready, d_busy, d_err;
    logic [NU-1:0] d_gate;
    logic [7:0]  d_clkw;
    logic [1:0]  d_mode;

    logic        s_valid = 1'b0;
    logic        a_ready, a_busy, a_err, b_ready, b_busy, b_err;
    logic [NU-1:0] a_gate, b_gate;
    logic [7:0]  a_clkw, b_clkw;
    logic [1:0]  a_mode, b_mode;

    int tests = 0, fails = 0;
    bit cmp_en = 1'b0;

    pg_gate_ctrl #(.NUM_UNITS(NU), .IDX_W(5), .CNT_W(2), .CLK_W(8),
                   .SETTLE_CYCLES(SETTLE), .INIT_MODE(2'd0)) i_pg_gate_ctrl (
        .clk(clk), .rst(rst), .req_valid(r_valid), .req_ready(d_ready),
        .req_unit(r_unit), .req_on(r_on), .req_clock(r_clk),
        .gate_vec(d_gate), .clock_word(d_clkw), .mode(d_mode),
        .busy(d_busy), .err(d_err));

    pg_gate_ctrl #(.NUM_UNITS(NU), .IDX_W(5), .CNT_W(2), .CLK_W(8),
                   .SETTLE_CYCLES(SETTLE), .INIT_MODE(2'd2)) i_pg_gate_ctrl_m2 (
        .clk(clk), .rst(rst), .req_valid(s_valid), .req_ready(a_ready),
        .req_unit(5'd0), .req_on(1'b1), .req_clock(8'h5A),
        .gate_vec(a_gate), .clock_word(a_clkw), .mode(a_mode),
        .busy(a_busy), .err(a_err));

    pg_gate_ctrl #(.NUM_UNITS(NU), .IDX_W(5), .CNT_W(2), .CLK_W(8),
                   .SETTLE_CYCLES(SETTLE), .INIT_MODE(2'd3)) i_pg_gate_ctrl_m3 (
        .clk(clk), .rst(rst), .req_valid(s_valid), .req_ready(b_ready),
        .req_unit(5'd0), .req_on(1'b1), .req_clock(8'h5A),
        .gate_vec(b_gate), .clock_word(b_clkw), .mode(b_mode),
        .busy(b_busy), .err(b_err));

    // behavioural reference for the main instance
    int          mc [NU];
    bit [NU-1:0] ms0, ms1;
    int          mk0, mk1, mmode, mtim;
    bit          merr;

    task automatic model_req(input int u, input bit on, input int ck);
        int c, nc;
        bit cur, nb;
        if (u >= NU) begin
            merr = 1'b1;
        end else begin
            c = mc[u];
            if (on ? (c == MAXC) : (c == 0)) begin
                merr = 1'b1;
            end else begin
                nc  = on ? c + 1 : c - 1;
                cur = (mmode == 1) ? ms1[u] : ms0[u];
                nb  = (nc != 0);
                if (nb == cur) begin
                    mc[u] = nc;
                end else if (mmode == 3) begin
                    merr = 1'b1;
                end else begin
                    mc[u] = nc;
                    if (mmode == 1) begin
                        ms0 = ms1; ms0[u] = nb; mk0 = ck; mmode = 0;
                    end else begin
                        ms1 = ms0; ms1[u] = nb; mk1 = ck; mmode = 1;
                    end
                    mtim = SETTLE;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NU; i++) mc[i] = 0;
            ms0 = '0; ms1 = '0; mk0 = 0; mk1 = 0; mmode = 0; mtim = 0; merr = 1'b0;
        end else begin
            bit tk;
            tk   = r_valid && (mtim == 0);
            merr = 1'b0;
            if (mtim > 0) mtim--;
            if (tk) model_req(int'(r_unit), r_on, int'(r_clk));
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R2",  "gate_vec",   int'(d_gate), int'((mmode == 1) ? ms1 : ms0));
            chk("R12", "clock_word", int'(d_clkw), (mmode == 1) ? mk1 : mk0);
            chk("R7",  "mode",       int'(d_mode), mmode);
            chk("R9",  "busy",       int'(d_busy), int'(mtim != 0));
            chk("R10", "req_ready",  int'(d_ready), int'(mtim == 0));
            chk("R11", "err",        int'(d_err),  int'(merr));
        end
    end

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input int u, input bit on, input int ck);
        bit acc;
        r_unit  = u[4:0];
        r_on    = on;
        r_clk   = ck[7:0];
        r_valid = 1'b1;
        forever begin
            acc = d_ready;
            @(negedge clk);
            if (acc) break;
        end
        r_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "gate", int'(d_gate), 0);
        chk("R1", "clock", int'(d_clkw), 0);
        chk("R1", "mode", int'(d_mode), 0);
        chk("R1", "busy", int'(d_busy), 0);
        chk("R1", "ready", int'(d_ready), 1);
        chk("R1", "mode m2", int'(a_mode), 2);
        chk("R1", "mode m3", int'(b_mode), 3);
        cmp_en = 1'b1;

        // alternate-mode instances
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        chk("R7", "m2 mode", int'(a_mode), 1);
        chk("R7", "m2 gate", int'(a_gate), 1);
        chk("R12", "m2 clock", int'(a_clkw), 8'h5A);
        chk("R8", "m3 err", int'(b_err), 1);
        chk("R8", "m3 mode", int'(b_mode), 3);
        chk("R8", "m3 gate", int'(b_gate), 0);
        chk("R8", "m3 busy", int'(b_busy), 0);
        @(negedge clk);
        chk("R11", "m3 err pulse", int'(b_err), 0);

        send(3, 1'b0, 8'h00);
        chk("R3", "err off at zero", int'(d_err), 1);
        chk("R3", "gate", int'(d_gate), 0);
        send(20, 1'b1, 8'h00);
        chk("R4", "err idx 20", int'(d_err), 1);
        send(31, 1'b1, 8'h00);
        chk("R4", "err idx 31", int'(d_err), 1);
        chk("R4", "mode", int'(d_mode), 0);

        send(3, 1'b1, 8'hA5);
        chk("R7", "mode after first switch", int'(d_mode), 1);
        chk("R12", "clock", int'(d_clkw), 8'hA5);
        chk("R9", "busy", int'(d_busy), 1);
        send(3, 1'b1, 8'h11);          // queued behind settle period
        chk("R10", "queued accepted gate", int'(d_gate), 32'h8);
        chk("R6", "clock kept", int'(d_clkw), 8'hA5);
        chk("R6", "no busy", int'(d_busy), 0);
        send(3, 1'b1, 8'h22);
        send(3, 1'b1, 8'h33);
        chk("R5", "err at max count", int'(d_err), 1);
        send(7, 1'b1, 8'h3C);
        chk("R7", "mode back to 0", int'(d_mode), 0);
        chk("R2", "gate 3 and 7", int'(d_gate), 32'h88);
        send(3, 1'b0, 8'h00);
        send(3, 1'b0, 8'h00);
        send(3, 1'b0, 8'h44);
        chk("R2", "unit 3 released", int'(d_gate), 32'h80);

        // pseudo-random traffic checked by the model
        seed = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            int gap;
            seed = seed * 1103515245 + 12345;
            gap  = (seed >>> 20) & 3;
            send(((seed >>> 8) & 32'h7FFF) % 24, ((seed >>> 4) % 3) != 0, (seed >>> 12) & 8'hFF);
            repeat (gap) @(negedge clk);
        end
        repeat (SETTLE + 2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule